// File: doc/BRIEF.md
# Reset-Time Configuration Autoloader

This block copies a fixed set of eight 32-bit words from a boot ROM into configuration and bank-size registers once reset is released. It is gated by an active-low strap pin that is sampled while reset is held. When the strap is low, the sequencer reads the ROM words one at a time over a simple read handshake. It writes each word to its register over a single-cycle write port. When the strap is high, nothing is loaded, so the register file keeps its reset defaults (for example a class code of 0x0580).

While the load runs, the block raises `busy`. The PCI target logic raises `pci_hit` for any access aimed at the device, and the block answers it with `pci_retry` while `busy` is high. A one-cycle `done` pulse marks the end of the load, and `busy` drops in that same cycle.

The sequencer has five states. LD_IDLE is the reset state. It moves to LD_FETCH when the load is enabled and to LD_PARKED when it is skipped. LD_FETCH holds the ROM strobe and moves to LD_STORE when `rom_ready` arrives. LD_STORE writes the captured word. From there it returns to LD_FETCH for the next entry, or goes to LD_FINISH after the eighth entry. LD_FINISH pulses `done` and moves to LD_PARKED, which is terminal until the next reset. Reset from any state returns the sequencer to LD_IDLE.

Top module: `cfg_autoloader`

## Requirements
- R1: `strap_n` is sampled only while `rst_n` is low. If it was low, a load runs after reset. If it was high, there are no ROM reads, no register writes, `busy` stays 0 and there is no `done`. Changes of `strap_n` after reset release have no effect.
- R2: The ROM is read exactly eight times, at 0x1FFFFFE0, 0x1FFFFFE4, up to 0x1FFFFFFC, in ascending order.
- R3: The n-th register write (n = 0..7) goes to offset 0x000, 0x008, 0x02C, 0x03C, 0xC08, 0xC0C, 0xC10, 0xC14 respectively.
- R4: `rom_rd` stays high with a stable `rom_addr` until `rom_ready` is seen high at a clock edge. The register write follows in the very next cycle and carries the `rom_rdata` captured at that edge.
- R5: `reg_we` is high for exactly one cycle per entry, and a load makes exactly eight writes.
- R6: `done` is high for exactly one cycle, the cycle right after the eighth write, and occurs once per load.
- R7: When a load runs, `busy` is high from the first cycle after the first clock edge following reset release until `done`. It is 0 from the `done` cycle onward. `pci_retry` equals `pci_hit` while `busy` is high and is 0 otherwise.
- R8: Asserting reset in the middle of a load aborts it at once. After release, the load restarts from the first entry and still makes exactly eight writes.
- R9: While reset is held, `rom_rd`, `reg_we`, `busy`, `done` and `pci_retry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 1 | Autoload enable strap, active low, sampled during reset |
| rom_addr | output | 32 | ROM byte address |
| rom_rd | output | 1 | ROM read strobe, held until ready |
| rom_rdata | input | 32 | ROM read data, valid with rom_ready |
| rom_ready | input | 1 | ROM read completion |
| reg_addr | output | 12 | Destination register offset |
| reg_wdata | output | 32 | Register write data |
| reg_we | output | 1 | Register write enable, one cycle |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse at end of load |
| pci_hit | input | 1 | A PCI access targets the device |
| pci_retry | output | 1 | Answer the current PCI access with retry |

## Verification
The hardest situation to reach is a reset that lands partway through a load, with a ROM read still pending and the strap re-sampled. It must produce a clean restart from the first entry, with no write left over from the aborted pass. The bench gets there by watching the write count at the ports and pulling reset right after a chosen write while the ROM responder is mid-latency. It then checks the full eight-entry sequence after release. Random ROM latencies, random strap values and random `pci_hit` traffic cover the hold, order and retry rules around these directed runs.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_FETCH,
        LD_STORE,
        LD_FINISH,
        LD_PARKED
    } ld_state_e;

    // Destination offset for each table entry; the order matters.
    function automatic logic [11:0] entry_offset(input int unsigned i);
        logic [11:0] off;
        unique case (i)
            0:       off = 12'h000;
            1:       off = 12'h008;
            2:       off = 12'h02C;
            3:       off = 12'h03C;
            4:       off = 12'hC08;
            5:       off = 12'hC0C;
            6:       off = 12'hC10;
            7:       off = 12'hC14;
            default: off = 12'h000;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/cfg_entry_map.sv
module cfg_entry_map
    import cfg_autoload_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          OFF_W    = 12,
    parameter int          N_ENT    = 8,
    parameter logic [31:0] ROM_BASE = 32'h1FFF_FFE0,
    parameter int          IDX_W    = $clog2(N_ENT)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [OFF_W-1:0]  reg_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    // ROM words are consecutive 32-bit locations from the base upward.
    assign rom_addr = ADDR_W'(ROM_BASE) + {{PAD_W{1'b0}}, idx, 2'b00};
    assign reg_addr = OFF_W'(entry_offset(int'(idx)));

endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_autoload_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_ENT  = 8,
    parameter int IDX_W  = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rom_ready,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [IDX_W-1:0]  idx,
    output logic              rom_rd,
    output logic              reg_we,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    ld_state_e state, nxt;

    // State register, entry index and captured ROM word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
            idx   <= '0;
            wdata <= '0;
        end else begin
            state <= nxt;
            if (state == LD_FETCH && rom_ready)
                wdata <= rom_rdata;
            if (state == LD_STORE)
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:   nxt = enable ? LD_FETCH : LD_PARKED;
            LD_FETCH:  nxt = rom_ready ? LD_STORE : LD_FETCH;
            LD_STORE:  nxt = (idx == LAST_IDX) ? LD_FINISH : LD_FETCH;
            LD_FINISH: nxt = LD_PARKED;
            LD_PARKED: nxt = LD_PARKED;
            default:   nxt = LD_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        rom_rd = 1'b0;
        reg_we = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state)
            LD_FETCH:  begin rom_rd = 1'b1; busy = 1'b1; end
            LD_STORE:  begin reg_we = 1'b1; busy = 1'b1; end
            LD_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd && !rom_ready |=> rom_rd && $stable(idx)) else $error("fetch hold"); // R4
    AST_WRITE_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd && rom_ready |=> reg_we && wdata == $past(rom_rdata)) else $error("write after ready"); // R4
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we) else $error("we pulse"); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(reg_we) && $past(idx) == LAST_IDX) else $error("done timing"); // R6
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy) else $error("done once"); // R6
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !rom_rd && !reg_we && !done) else $error("skip quiet"); // R1

endmodule

// File: rtl/cfg_autoloader.sv
module cfg_autoloader #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          OFF_W    = 12,
    parameter int          N_ENT    = 8,
    parameter logic [31:0] ROM_BASE = 32'h1FFF_FFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_n,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              rom_ready,
    output logic [OFF_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              busy,
    output logic              done,
    input  logic              pci_hit,
    output logic              pci_retry
);
    localparam int IDX_W = $clog2(N_ENT);

    logic             load_en;
    logic [IDX_W-1:0] idx;

    // Strap is captured on every clock edge while reset is held, frozen after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_en <= ~strap_n;
    end

    cfg_load_fsm #(
        .DATA_W (DATA_W),
        .N_ENT  (N_ENT),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (load_en),
        .rom_ready (rom_ready),
        .rom_rdata (rom_rdata),
        .idx       (idx),
        .rom_rd    (rom_rd),
        .reg_we    (reg_we),
        .wdata     (reg_wdata),
        .busy      (busy),
        .done      (done)
    );

    cfg_entry_map #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .N_ENT    (N_ENT),
        .ROM_BASE (ROM_BASE),
        .IDX_W    (IDX_W)
    ) u_map (
        .idx      (idx),
        .rom_addr (rom_addr),
        .reg_addr (reg_addr)
    );

    assign pci_retry = pci_hit & busy;

    AST_RD_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd || reg_we) |-> busy) else $error("busy during load"); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !$past(reg_we) |-> rom_addr == $past(rom_addr)) else $error("addr step"); // R2

endmodule

// File: tb/sim_cfg_autoloader.sv
`timescale 1ns/1ps
module sim_cfg_autoloader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_n = 1'b1;
    logic [31:0] rom_addr;
    logic        rom_rd;
    logic [31:0] rom_rdata = '0;
    logic        rom_ready = 1'b0;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic        busy;
    logic        done;
    logic        pci_hit = 1'b0;
    logic        pci_retry;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cfg_autoloader u0 (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata), .rom_ready(rom_ready),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .busy(busy), .done(done), .pci_hit(pci_hit), .pci_retry(pci_retry)
    );

    function automatic logic [31:0] exp_addr(input int i);
        return 32'h1FFF_FFE0 + 32'(i * 4);
    endfunction

    function automatic logic [11:0] exp_off(input int i);
        case (i)
            0: return 12'h000; 1: return 12'h008; 2: return 12'h02C; 3: return 12'h03C;
            4: return 12'hC08; 5: return 12'hC0C; 6: return 12'hC10; default: return 12'hC14;
        endcase
    endfunction

    logic [31:0] salt = 32'h0;
    function automatic logic [31:0] rom_word(input logic [31:0] a, input logic [31:0] s);
        return {a[15:0], ~a[15:0]} ^ s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Records of the current run
    logic [31:0] rd_a [16];
    logic [11:0] wr_o [16];
    logic [31:0] wr_d [16];
    int nr, nw, ndone, nclk, last_we_clk, done_clk;
    logic en_run = 1'b0;
    logic prev_rd = 1'b0;
    logic [31:0] hold_a = '0;
    logic ready_given = 1'b0;
    int lat = 0;

    task automatic clear_rec();
        nr = 0; nw = 0; ndone = 0; nclk = 0; last_we_clk = -1; done_clk = -1;
        prev_rd = 1'b0; ready_given = 1'b0;
    endtask

    // Monitor, then ROM responder and PCI traffic, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ready_given) chk("R4 write after ready", {31'b0, reg_we}, 32'd1);
            if (rom_rd && prev_rd) chk("R4 addr stable", rom_addr, hold_a);
            if (rom_rd && !prev_rd) begin
                if (nr < 16) rd_a[nr] = rom_addr;
                nr++;
                hold_a = rom_addr;
            end
            if (reg_we) begin
                if (nw < 16) begin wr_o[nw] = reg_addr; wr_d[nw] = reg_wdata; end
                nw++;
                last_we_clk = nclk;
            end
            if (done) begin
                chk("R6 busy low at done", {31'b0, busy}, 32'd0);
                ndone++;
                done_clk = nclk;
            end else begin
                chk("R7 busy", {31'b0, busy}, {31'b0, en_run && nclk >= 1 && ndone == 0});
            end
            chk("R7 retry", {31'b0, pci_retry}, {31'b0, pci_hit && busy});
            prev_rd = rom_rd;
            nclk++;
            // drive
            ready_given = 1'b0;
            if (rom_ready) rom_ready = 1'b0;
            else if (rom_rd) begin
                if (lat == 0) begin
                    rom_ready = 1'b1;
                    rom_rdata = rom_word(rom_addr, salt);
                    ready_given = 1'b1;
                    lat = int'($urandom % 4);
                end else lat--;
            end
            pci_hit = $urandom % 2 == 0;
        end else begin
            rom_ready = 1'b0;
        end
    end

    task automatic run(input logic strap, input int abort_after);
        @(posedge clk); #2;
        rst_n = 1'b0; strap_n = strap; salt = $urandom; lat = int'($urandom % 4);
        repeat (3) @(posedge clk);
        #2;
        chk("R9 rom_rd in reset", {31'b0, rom_rd}, 32'd0);
        chk("R9 reg_we in reset", {31'b0, reg_we}, 32'd0);
        chk("R9 busy/done/retry in reset", {29'b0, busy, done, pci_retry}, 32'd0);
        clear_rec();
        en_run = !strap;
        rst_n = 1'b1;
        strap_n = $urandom % 2;   // must be ignored (R1)
        if (abort_after > 0) begin
            for (int t = 0; t < 200 && nw < abort_after; t++) @(posedge clk);
            #2;
            rst_n = 1'b0;
            strap_n = strap;
            #1;
            chk("R8 abort clears outputs", {29'b0, rom_rd, reg_we, busy}, 32'd0);
            repeat (2) @(posedge clk);
            #2;
            clear_rec();
            rst_n = 1'b1;
        end
        for (int t = 0; t < 120; t++) @(posedge clk);
        #2;
        if (en_run) begin
            chk("R2 read count", nr, 8);
            chk("R5 write count", nw, 8);
            chk("R6 done count", ndone, 1);
            chk("R6 done follows last write", done_clk, last_we_clk + 1);
            for (int i = 0; i < 8 && i < nr && i < nw; i++) begin
                chk("R2 rom address", rd_a[i], exp_addr(i));
                chk("R3 reg offset", {20'b0, wr_o[i]}, {20'b0, exp_off(i)});
                chk("R4 write data", wr_d[i], rom_word(exp_addr(i), salt));
            end
            if (abort_after > 0) chk("R8 restart at first entry", {20'b0, wr_o[0]}, 32'h000);
        end else begin
            chk("R1 no reads when skipped", nr, 0);
            chk("R1 no writes when skipped", nw, 0);
            chk("R1 no done when skipped", ndone, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20211102));
        clear_rec();
        run(1'b1, 0);          // skipped load
        run(1'b0, 0);          // normal load
        run(1'b0, 3);          // abort after third write
        run(1'b0, 7);          // abort just before the last write
        for (int k = 0; k < 6; k++) run(1'($urandom % 2), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule